// File: doc/BRIEF.md
# Byte Block Copy Sequencer

This block moves bytes from one memory region to another using three working registers: a source pointer, a destination pointer and a byte count. A CPU core that implements string-move instructions hands the block the current register values and a flag byte, pulses `start`, and reads the updated registers and flags back when `done` rises. Each step reads the byte at the source address over a synchronous read port, writes that byte to the destination address over a write port, then moves both pointers forward by one and lowers the count by one.

Two modes exist. In single mode the block performs exactly one step. In repeat mode it keeps stepping until the count reaches zero. A count of zero at entry therefore wraps and covers the whole count range. After every step the flag byte is rewritten in a fixed way. Sign, zero and carry are kept. Half-carry, subtract and the two unused bits are cleared. Bit 2 reports whether bytes remain. A cost output totals a fixed cycle charge per step so that the core can account for time.

Top module: `blkcopy_engine`

## Requirements
- R1: While idle, a high `start` loads `src_in`, `dst_in`, `cnt_in`, `flags_in` and `repeat_mode` and raises `busy` on the next clock. While busy, `start` and the register inputs have no effect.
- R2: Each step drives `mem_rd_en` with `mem_rd_addr` equal to the source pointer. In the next cycle it drives `mem_wr_en` with `mem_wr_addr` equal to the destination pointer and `mem_wr_data` equal to the byte the memory returned (read data appears one cycle after `mem_rd_en`). A read and a write never share a cycle.
- R3: After each step the source and destination pointers have each risen by one, modulo 2^PTR_W.
- R4: After each step the count has fallen by one, modulo 2^CNT_W. A count of 0 becomes all ones.
- R5: After each step flag bits 7, 6 and 0 equal their values before the step.
- R6: After each step flag bits 5, 4, 3 and 1 are 0.
- R7: After each step flag bit 2 is 1 when the new count is nonzero and 0 otherwise.
- R8: With `repeat_mode` low at start, exactly one step is performed, then `done` is raised.
- R9: With `repeat_mode` high at start, steps continue until the count is zero after a step, then `done` is raised. A starting count of 0 gives 2^CNT_W steps.
- R10: `done` is high for exactly one cycle, in the cycle after the last write. The register, flag and cost outputs already hold their final values in that cycle and keep them until the next start.
- R11: `cost_out` is cleared at start and rises by STEP_COST (default 16) with every step.
- R12: While reset is asserted and right after it, all register outputs, `cost_out`, `busy`, `done` and both memory enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| repeat_mode | input | 1 | 0 = single step, 1 = repeat until count is zero |
| src_in | input | PTR_W | Initial source pointer |
| dst_in | input | PTR_W | Initial destination pointer |
| cnt_in | input | CNT_W | Initial byte count |
| flags_in | input | 8 | Initial flag byte |
| src_out | output | PTR_W | Current source pointer |
| dst_out | output | PTR_W | Current destination pointer |
| cnt_out | output | CNT_W | Current byte count |
| flags_out | output | 8 | Current flag byte |
| cost_out | output | COST_W | Cycle charge of the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | PTR_W | Memory read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | PTR_W | Memory write address |
| mem_wr_data | output | 8 | Memory write data |

## Verification
The bench builds the block with PTR_W = 16 and CNT_W = 8, and leaves STEP_COST and COST_W at their defaults. The narrow count makes a repeat run that starts from a count of zero a 256-step copy. This brings the wrap of the count and the full-range repeat within a short run. The full-width pointers still let a copy cross the top of the address space at 0xFFFF. Overlapping source and destination ranges show that each write depends on the read just before it.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } cp_state_e;

  // flag bits carried through a step unchanged: sign, zero, carry
  localparam logic [7:0] FLAG_KEEP = 8'hC1;
  // bit reporting "bytes remain"
  localparam int FLAG_REMAIN_BIT = 2;

  function automatic logic [7:0] step_flags(input logic [7:0] old_f,
                                            input logic       remain);
    logic [7:0] f;
    f                  = old_f & FLAG_KEEP;
    f[FLAG_REMAIN_BIT] = remain;
    return f;
  endfunction

endpackage

// File: rtl/blkcopy_ctrl.sv
module blkcopy_ctrl
  import blkcopy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic repeat_mode,
  input  logic cnt_dec_nz,
  output logic load_ev,
  output logic rd_ph,
  output logic wr_ph,
  output logic last_step,
  output logic busy_o,
  output logic done_o,
  output logic rep_q_o
);

  cp_state_e state_q, state_d;
  logic      rep_q;

  assign load_ev   = (state_q == ST_IDLE) && start;
  assign rd_ph     = (state_q == ST_READ);
  assign wr_ph     = (state_q == ST_WRITE);
  assign last_step = wr_ph && !(rep_q && cnt_dec_nz);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign rep_q_o   = rep_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = last_step ? ST_DONE : ST_READ;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rep_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_ev) rep_q <= repeat_mode;
    end
  end

endmodule

// File: rtl/blkcopy_dpath.sv
module blkcopy_dpath
  import blkcopy_pkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int CNT_W     = 16,
  parameter int COST_W    = 24,
  parameter int STEP_COST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ev,
  input  logic              step_ev,
  input  logic [PTR_W-1:0]  src_in,
  input  logic [PTR_W-1:0]  dst_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [7:0]        flags_in,
  output logic [PTR_W-1:0]  src_q,
  output logic [PTR_W-1:0]  dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [7:0]        flags_q,
  output logic [COST_W-1:0] cost_q,
  output logic              cnt_dec_nz
);

  localparam int                NUM_PTR   = 2;
  localparam logic [COST_W-1:0] COST_STEP = COST_W'(STEP_COST);
  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

  logic [PTR_W-1:0] ptr_init [NUM_PTR];
  logic [CNT_W-1:0] cnt_dec;

  assign ptr_init[0] = src_in;
  assign ptr_init[1] = dst_in;

  // both pointers advance in lockstep; one register per pointer
  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic [PTR_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (load_ev) q <= ptr_init[g];
      else if (step_ev) q <= q + 1'b1;
    end
  end

  assign src_q = g_ptr[0].q;
  assign dst_q = g_ptr[1].q;

  assign cnt_dec    = cnt_q - CNT_ONE;
  assign cnt_dec_nz = |cnt_dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flags_q <= '0;
      cost_q  <= '0;
    end else if (load_ev) begin
      cnt_q   <= cnt_in;
      flags_q <= flags_in;
      cost_q  <= '0;
    end else if (step_ev) begin
      cnt_q   <= cnt_dec;
      flags_q <= step_flags(flags_q, cnt_dec_nz);
      cost_q  <= cost_q + COST_STEP;
    end
  end

endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
  import blkcopy_pkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int CNT_W     = 16,
  parameter int COST_W    = 24,
  parameter int STEP_COST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              repeat_mode,
  input  logic [PTR_W-1:0]  src_in,
  input  logic [PTR_W-1:0]  dst_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [7:0]        flags_in,
  output logic [PTR_W-1:0]  src_out,
  output logic [PTR_W-1:0]  dst_out,
  output logic [CNT_W-1:0]  cnt_out,
  output logic [7:0]        flags_out,
  output logic [COST_W-1:0] cost_out,
  output logic              busy,
  output logic              done,
  output logic              mem_rd_en,
  output logic [PTR_W-1:0]  mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [PTR_W-1:0]  mem_wr_addr,
  output logic [7:0]        mem_wr_data
);

  // named internal events, also watched by the checker
  logic load_ev;
  logic rd_ph;
  logic wr_ph;
  logic last_step;
  logic rep_mode_q;
  logic cnt_dec_nz;

  blkcopy_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .repeat_mode (repeat_mode),
    .cnt_dec_nz  (cnt_dec_nz),
    .load_ev     (load_ev),
    .rd_ph       (rd_ph),
    .wr_ph       (wr_ph),
    .last_step   (last_step),
    .busy_o      (busy),
    .done_o      (done),
    .rep_q_o     (rep_mode_q)
  );

  blkcopy_dpath #(
    .PTR_W     (PTR_W),
    .CNT_W     (CNT_W),
    .COST_W    (COST_W),
    .STEP_COST (STEP_COST)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_ev    (load_ev),
    .step_ev    (wr_ph),
    .src_in     (src_in),
    .dst_in     (dst_in),
    .cnt_in     (cnt_in),
    .flags_in   (flags_in),
    .src_q      (src_out),
    .dst_q      (dst_out),
    .cnt_q      (cnt_out),
    .flags_q    (flags_out),
    .cost_q     (cost_out),
    .cnt_dec_nz (cnt_dec_nz)
  );

  // memory port: read in one phase, write the returned byte in the next
  assign mem_rd_en   = rd_ph;
  assign mem_rd_addr = src_out;
  assign mem_wr_en   = wr_ph;
  assign mem_wr_addr = dst_out;
  assign mem_wr_data = mem_rd_data;

endmodule

// File: rtl/blkcopy_chk.sv
module blkcopy_chk #(
  parameter int PTR_W     = 16,
  parameter int CNT_W     = 16,
  parameter int COST_W    = 24,
  parameter int STEP_COST = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_ev,
  input logic              last_step,
  input logic              rep_mode_q,
  input logic              busy,
  input logic              done,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [PTR_W-1:0]  src_out,
  input logic [PTR_W-1:0]  dst_out,
  input logic [CNT_W-1:0]  cnt_out,
  input logic [7:0]        flags_out,
  input logic [COST_W-1:0] cost_out
);

  localparam logic [COST_W-1:0] COST_STEP = COST_W'(STEP_COST);
  localparam logic [PTR_W-1:0]  PTR_ONE   = PTR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

  // R1
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> busy);

  // R2
  rd_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en));

  // R2
  wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_wr_en);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_wr_en) |-> (src_out == $past(src_out) + PTR_ONE) &&
                         (dst_out == $past(dst_out) + PTR_ONE));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_wr_en) |-> cnt_out == $past(cnt_out) - CNT_ONE);

  // R5
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_wr_en) |-> (flags_out & 8'hC1) == ($past(flags_out) & 8'hC1));

  // R6
  clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags_out & 8'h3A) == 8'h00);

  // R7
  remain_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags_out[2] == (cnt_out != '0));

  // R8
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !rep_mode_q) |=> done);

  // R9
  repeat_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rep_mode_q) |-> cnt_out == '0);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done);

  // R11
  cost_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_wr_en) |-> cost_out == $past(cost_out) + COST_STEP);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd_en && !mem_wr_en && !done);

endmodule

bind blkcopy_engine blkcopy_chk #(
  .PTR_W     (PTR_W),
  .CNT_W     (CNT_W),
  .COST_W    (COST_W),
  .STEP_COST (STEP_COST)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_ev    (load_ev),
  .last_step  (last_step),
  .rep_mode_q (rep_mode_q),
  .busy       (busy),
  .done       (done),
  .mem_rd_en  (mem_rd_en),
  .mem_wr_en  (mem_wr_en),
  .src_out    (src_out),
  .dst_out    (dst_out),
  .cnt_out    (cnt_out),
  .flags_out  (flags_out),
  .cost_out   (cost_out)
);

// File: tb/blkcopy_engine_tb_top.sv
`timescale 1ns/1ps
module blkcopy_engine_tb_top;

  localparam int PTR_W  = 16;
  localparam int CNT_W  = 8;
  localparam int COST_W = 24;
  localparam int STEP_C = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              repeat_mode = 1'b0;
  logic [PTR_W-1:0]  src_in = '0;
  logic [PTR_W-1:0]  dst_in = '0;
  logic [CNT_W-1:0]  cnt_in = '0;
  logic [7:0]        flags_in = '0;
  logic [PTR_W-1:0]  src_out, dst_out, mem_rd_addr, mem_wr_addr;
  logic [CNT_W-1:0]  cnt_out;
  logic [7:0]        flags_out, mem_wr_data;
  logic [7:0]        mem_rd_data = '0;
  logic [COST_W-1:0] cost_out;
  logic              busy, done, mem_rd_en, mem_wr_en;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  blkcopy_engine #(.PTR_W(PTR_W), .CNT_W(CNT_W), .COST_W(COST_W), .STEP_COST(STEP_C)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .repeat_mode(repeat_mode),
    .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .flags_in(flags_in),
    .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out), .flags_out(flags_out),
    .cost_out(cost_out), .busy(busy), .done(done),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  // ---------------- memories: bench-side and reference copy ----------------
  byte unsigned bus_mem [int];
  byte unsigned ref_mem [int];

  function automatic byte unsigned fill(int a);
    return byte'((a * 37 + (a >> 8) + 5) & 8'hFF);
  endfunction

  function automatic byte unsigned bus_rd(int a);
    return bus_mem.exists(a) ? bus_mem[a] : fill(a);
  endfunction

  function automatic byte unsigned ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : fill(a);
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= bus_rd(int'(mem_rd_addr));
    if (mem_wr_en) bus_mem[int'(mem_wr_addr)] = mem_wr_data;
  end

  // ---------------- behavioural reference model ----------------
  int               m_ph = 0;   // 0 idle, 1 reading, 2 writing, 3 finished
  bit               m_rep = 0;
  int               m_src = 0, m_dst = 0, m_cnt = 0, m_cost = 0;
  int               m_flg = 0;
  int               m_byte = 0;
  localparam int PMOD = 1 << PTR_W;
  localparam int CMOD = 1 << CNT_W;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_rep = 0; m_src = 0; m_dst = 0; m_cnt = 0; m_flg = 0; m_cost = 0;
    end else begin
      case (m_ph)
        0: if (start) begin
             m_src = src_in; m_dst = dst_in; m_cnt = cnt_in; m_flg = flags_in;
             m_rep = repeat_mode; m_cost = 0; m_ph = 1;
           end
        1: begin m_byte = ref_rd(m_src); m_ph = 2; end
        2: begin
             ref_mem[m_dst] = byte'(m_byte);
             m_src = (m_src + 1) % PMOD;
             m_dst = (m_dst + 1) % PMOD;
             m_cnt = (m_cnt + CMOD - 1) % CMOD;
             // keep sign/zero/carry, drop the rest, bit 2 = bytes remain
             m_flg = (m_flg & 'hC1) | ((m_cnt != 0) ? 4 : 0);
             m_cost = m_cost + STEP_C;
             m_ph = (m_rep && m_cnt != 0) ? 1 : 3;
           end
        default: m_ph = 0;
      endcase
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare against the model every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy == (m_ph != 0), "R1 busy", busy, m_ph != 0);
      chk(mem_rd_en == (m_ph == 1), "R2 rd_en", mem_rd_en, m_ph == 1);
      chk(mem_wr_en == (m_ph == 2), "R2 wr_en", mem_wr_en, m_ph == 2);
      if (m_ph == 1) chk(int'(mem_rd_addr) == m_src, "R2 rd_addr", mem_rd_addr, m_src);
      if (m_ph == 2) begin
        chk(int'(mem_wr_addr) == m_dst, "R2 wr_addr", mem_wr_addr, m_dst);
        chk(int'(mem_wr_data) == m_byte, "R2 wr_data", mem_wr_data, m_byte);
      end
      chk(int'(src_out) == m_src, "R3 src", src_out, m_src);
      chk(int'(dst_out) == m_dst, "R3 dst", dst_out, m_dst);
      chk(int'(cnt_out) == m_cnt, "R4 cnt", cnt_out, m_cnt);
      chk((flags_out & 8'hC1) == (m_flg & 'hC1), "R5 kept flags", flags_out, m_flg);
      chk((flags_out & 8'h3A) == (m_flg & 'h3A), "R6 cleared flags", flags_out, m_flg);
      chk(flags_out[2] == m_flg[2], "R7 remain bit", flags_out, m_flg);
      chk(done == (m_ph == 3), "R10 done", done, m_ph == 3);
      chk(int'(cost_out) == m_cost, "R11 cost", cost_out, m_cost);
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_op(int s, int d, int c, int f, bit rep, int exp_steps, bit poke);
    int steps = 0;
    int guard = 0;
    @(negedge clk);
    src_in = PTR_W'(s); dst_in = PTR_W'(d); cnt_in = CNT_W'(c);
    flags_in = 8'(f); repeat_mode = rep; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (mem_wr_en) steps++;
      // a second start while busy must be ignored (R1)
      if (poke && steps == 2) begin
        start = 1'b1; src_in = 16'h1234; cnt_in = 8'h07; flags_in = 8'h3A;
        repeat_mode = ~rep;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    if (rep) chk(steps == exp_steps, "R9 step count", steps, exp_steps);
    else     chk(steps == exp_steps, "R8 step count", steps, exp_steps);
    @(negedge clk);
    chk(!busy && !done, "R10 back to idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: outputs while in reset
    chk(!busy && !done && !mem_rd_en && !mem_wr_en, "R12 ctrl in reset", {busy, done}, 0);
    chk(src_out == 0 && dst_out == 0 && cnt_out == 0, "R12 regs in reset", src_out, 0);
    chk(flags_out == 0 && cost_out == 0, "R12 flags/cost in reset", flags_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && cost_out == 0, "R12 idle after reset", busy, 0);

    run_op('h0100, 'h0200, 5,    'hFF, 1'b0, 1, 1'b0);   // R8 single, flags all set
    run_op('h0101, 'h0201, 1,    'h00, 1'b0, 1, 1'b0);   // R7 count reaches zero
    run_op('h0300, 'h0400, 0,    'h3A, 1'b0, 1, 1'b0);   // R4 count wraps
    run_op('h0500, 'h0600, 6,    'hC5, 1'b1, 6, 1'b0);   // R9 repeat
    run_op('h0700, 'h0701, 9,    'h81, 1'b1, 9, 1'b0);   // R2 overlap replication
    run_op('hFFFD, 'hFFFE, 5,    'h41, 1'b1, 5, 1'b0);   // R3 pointer wrap
    run_op('h0800, 'h0900, 8,    'h01, 1'b1, 8, 1'b1);   // R1 start while busy
    run_op('h0A00, 'h0A10, 4,    'h10, 1'b0, 1, 1'b1);   // R1 single with poke
    run_op('h1000, 'h2000, 0,    'h7E, 1'b1, 256, 1'b0); // R9 zero count, full range

    // R2: every byte written on the bus matches the reference image
    begin
      int mism = 0;
      foreach (ref_mem[a]) if (bus_rd(a) != ref_mem[a]) mism++;
      chk(mism == 0, "R2 memory image", mism, 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R9 act=hung exp=done t=%0t", $time);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule